// File: doc/BRIEF.md
# Copy Request Descriptor Packer

This block takes a single memory copy request (source address, destination address, byte count) and turns it into the descriptor writes that a ring-based copy engine needs. The byte count is cut into chunks of at most 0x3F80 bytes. Transmit-side chunks are packed two to a descriptor, one in each of the descriptor's two buffer slots. Receive-side chunks get one descriptor each. When every descriptor word has been written, the block issues the new transmit CPU index, which hands the work to the engine.

Both rings have 8 entries of four 32-bit words. The block writes no memory itself. It emits one word write per cycle (ring, entry, word select, data) to whatever holds the rings, then one index-update strobe. The caller supplies the transmit ring's current CPU index and the receive ring's current CPU index with each request. Both values are sampled when the request is accepted.

Top module: `copy_desc_packer`

## Requirements
- R1: While reset is held and right after it, `req_ready_o` is 1 and `wr_valid_o`, `ctx_wr_o`, `done_o` and `err_o` are 0.
- R2: The length is split into chunks of min(remaining, 0x3F80) bytes, so the chunk count is the length divided by 0x3F80, rounded up. Each chunk's length appears in a 14-bit length field.
- R3: Chunk k with k even writes transmit descriptor T, where T starts at `tx_idx_i`. Word 0 gets the source address. Word 1 (flags) gets the chunk length in bits 29:16, with bit 31 (done) and bit 15 clear. T then advances by one modulo 8.
- R4: Chunk k with k odd writes word 2 of the descriptor written by chunk k-1 with the source address. It rewrites that descriptor's flags word with both lengths: the earlier chunk in bits 29:16 and this chunk in bits 13:0.
- R5: On the last transmit descriptor, bit 30 is set when the chunk count is odd and bit 14 is set when it is even. No other descriptor carries either bit.
- R6: Receive descriptors start at `rx_cpu_idx_i`+1 modulo 8, one per chunk, advancing modulo 8. Word 0 gets the destination address. Word 1 gets the chunk length in bits 29:16, with all other bits 0.
- R7: Source and destination addresses each advance by every chunk's length.
- R8: For each chunk, writes go out one per cycle in this order: transmit address, transmit flags, receive address, receive flags. After the last write, one cycle raises `ctx_wr_o` and `done_o` together, with `ctx_idx_o` holding the final transmit index.
- R9: A zero-length request is accepted and answered with a one-cycle `err_o`. It produces no write and no `done_o`.
- R10: A request longer than 16 × 0x3F80 bytes is answered the same way as a zero-length one.
- R11: Ring encoding is 0 = transmit and 1 = receive. Word select is 0 = first address, 1 = flags, 2 = second address. `req_ready_o` is low from acceptance until `done_o`, and `req_valid_i` has no effect while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Copy request present |
| req_ready_o | output | 1 | Block idle, request accepted this cycle if valid |
| req_src_i | input | 32 | Source byte address |
| req_dst_i | input | 32 | Destination byte address |
| req_len_i | input | 20 | Byte count |
| tx_idx_i | input | 3 | Current transmit CPU index |
| rx_cpu_idx_i | input | 3 | Current receive CPU index |
| wr_valid_o | output | 1 | Descriptor word write strobe |
| wr_ring_o | output | 1 | 0 transmit ring, 1 receive ring |
| wr_idx_o | output | 3 | Ring entry |
| wr_word_o | output | 2 | Word within descriptor |
| wr_data_o | output | 32 | Word value |
| ctx_wr_o | output | 1 | Transmit CPU index update strobe |
| ctx_idx_o | output | 3 | New transmit CPU index |
| done_o | output | 1 | Request finished |
| err_o | output | 1 | Request rejected |

## Verification
Lengths of one small chunk and of exactly 0x3F80 show whether the chunk boundary is inclusive. A length one byte over 0x3F80 forces a second chunk, which must move into the second slot and the low length field and take the even-count flag. A three-chunk request started at transmit index 7 and a single chunk at receive index 7 exercise index wrap on both rings. Exactly sixteen chunks, one byte beyond that, and zero length separate the largest accepted request from the rejected ones. A request held valid while the block is busy checks that no second descriptor stream starts.

// File: rtl/cpk_pkg.sv
package cpk_pkg;
  localparam int WORD_W    = 32;
  localparam int PLEN_W    = 14;
  localparam int PLEN0_LSB = 16;
  localparam int BIT_LS0   = 30;
  localparam int BIT_LS1   = 14;

  typedef enum logic [1:0] {
    W_ADDR0 = 2'd0,
    W_FLAGS = 2'd1,
    W_ADDR1 = 2'd2
  } word_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EMIT = 2'd1,
    ST_FIN  = 2'd2
  } pk_state_e;

  function automatic logic [WORD_W-1:0] pack_flags(
    input logic [PLEN_W-1:0] plen0,
    input logic [PLEN_W-1:0] plen1,
    input logic              ls0,
    input logic              ls1
  );
    logic [WORD_W-1:0] f;
    f = '0;
    f[PLEN0_LSB +: PLEN_W] = plen0;
    f[0 +: PLEN_W]         = plen1;
    f[BIT_LS0]             = ls0;
    f[BIT_LS1]             = ls1;
    return f;
  endfunction
endpackage

// File: rtl/chunk_walker.sv
module chunk_walker
  import cpk_pkg::*;
#(
  parameter int LEN_W     = 20,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 5,
  parameter int CHUNK_MAX = 16256
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                step_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [WORD_W-1:0]   src_i,
  input  logic [WORD_W-1:0]   dst_i,
  input  logic [IDX_W-1:0]    tx_i,
  input  logic [IDX_W-1:0]    rx_cpu_i,
  output logic [WORD_W-1:0]   src_o,
  output logic [WORD_W-1:0]   dst_o,
  output logic [PLEN_W-1:0]   tlen_o,
  output logic                last_o,
  output logic                odd_o,
  output logic [IDX_W-1:0]    tx_idx_o,
  output logic [IDX_W-1:0]    rx_idx_o
);
  localparam logic [LEN_W-1:0]  CHUNK_L = LEN_W'(CHUNK_MAX);
  localparam logic [PLEN_W-1:0] CHUNK_P = PLEN_W'(CHUNK_MAX);

  logic [LEN_W-1:0]  rem_q;
  logic [WORD_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  tx_q, rx_q, rx_base_q;
  logic              act_q;
  logic              big;

  assign big      = rem_q > CHUNK_L;
  assign tlen_o   = big ? CHUNK_P : rem_q[PLEN_W-1:0];
  assign last_o   = !big;
  assign odd_o    = cnt_q[0];
  assign src_o    = src_q;
  assign dst_o    = dst_q;
  assign tx_idx_o = tx_q;
  assign rx_idx_o = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q     <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      cnt_q     <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
      rx_base_q <= '0;
      act_q     <= 1'b0;
    end else if (load_i) begin
      rem_q     <= len_i;
      src_q     <= src_i;
      dst_q     <= dst_i;
      cnt_q     <= '0;
      tx_q      <= tx_i;
      rx_q      <= rx_cpu_i + IDX_W'(1);
      rx_base_q <= rx_cpu_i + IDX_W'(1);
      act_q     <= 1'b1;
    end else if (step_i) begin
      rem_q <= rem_q - LEN_W'(tlen_o);
      src_q <= src_q + WORD_W'(tlen_o);
      dst_q <= dst_q + WORD_W'(tlen_o);
      cnt_q <= cnt_q + CNT_W'(1);
      rx_q  <= rx_q + IDX_W'(1);
      // tx entry advances once per pair, on the even chunk
      if (!cnt_q[0]) tx_q <= tx_q + IDX_W'(1);
      if (last_o) act_q <= 1'b0;
    end
  end

  a_r2_chunk_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (tlen_o != '0) && (tlen_o <= CHUNK_P));

  a_r6_rx_tracks_chunks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> ((rx_q - rx_base_q) == cnt_q[IDX_W-1:0]));
endmodule

// File: rtl/desc_word_gen.sv
module desc_word_gen
  import cpk_pkg::*;
#(
  parameter int IDX_W     = 3,
  parameter int CHUNK_MAX = 16256
) (
  input  logic [1:0]        step_i,
  input  logic [WORD_W-1:0] src_i,
  input  logic [WORD_W-1:0] dst_i,
  input  logic [PLEN_W-1:0] tlen_i,
  input  logic              last_i,
  input  logic              odd_i,
  input  logic [IDX_W-1:0]  tx_idx_i,
  input  logic [IDX_W-1:0]  rx_idx_i,
  output logic              ring_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [1:0]        word_o,
  output logic [WORD_W-1:0] data_o
);
  localparam logic [PLEN_W-1:0] CHUNK_P = PLEN_W'(CHUNK_MAX);

  logic [IDX_W-1:0] tx_ent;

  // odd chunk fills the entry the even chunk already stepped past
  assign tx_ent = odd_i ? tx_idx_i - IDX_W'(1) : tx_idx_i;

  always_comb begin
    ring_o = 1'b0;
    idx_o  = tx_ent;
    word_o = W_ADDR0;
    data_o = src_i;
    unique case (step_i)
      2'd0: begin
        word_o = odd_i ? W_ADDR1 : W_ADDR0;
      end
      2'd1: begin
        word_o = W_FLAGS;
        data_o = odd_i ? pack_flags(CHUNK_P, tlen_i, 1'b0, last_i)
                       : pack_flags(tlen_i, '0, last_i, 1'b0);
      end
      2'd2: begin
        ring_o = 1'b1;
        idx_o  = rx_idx_i;
        data_o = dst_i;
      end
      default: begin
        ring_o = 1'b1;
        idx_o  = rx_idx_i;
        word_o = W_FLAGS;
        data_o = pack_flags(tlen_i, '0, 1'b0, 1'b0);
      end
    endcase
  end
endmodule

// File: rtl/copy_desc_packer.sv
module copy_desc_packer
  import cpk_pkg::*;
#(
  parameter int LEN_W      = 20,
  parameter int RING_DEPTH = 8,
  parameter int CHUNK_MAX  = 16256,
  parameter int MAX_CHUNKS = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic [31:0]                   req_src_i,
  input  logic [31:0]                   req_dst_i,
  input  logic [LEN_W-1:0]              req_len_i,
  input  logic [$clog2(RING_DEPTH)-1:0] tx_idx_i,
  input  logic [$clog2(RING_DEPTH)-1:0] rx_cpu_idx_i,
  output logic                          wr_valid_o,
  output logic                          wr_ring_o,
  output logic [$clog2(RING_DEPTH)-1:0] wr_idx_o,
  output logic [1:0]                    wr_word_o,
  output logic [31:0]                   wr_data_o,
  output logic                          ctx_wr_o,
  output logic [$clog2(RING_DEPTH)-1:0] ctx_idx_o,
  output logic                          done_o,
  output logic                          err_o
);
  localparam int IDX_W = $clog2(RING_DEPTH);
  localparam int CNT_W = $clog2(MAX_CHUNKS) + 1;
  localparam longint unsigned MAX_TOTAL = longint'(MAX_CHUNKS) * longint'(CHUNK_MAX);

  pk_state_e        state_q;
  logic [1:0]       step_q;
  logic             err_q;
  logic             accept, bad, load, adv;
  logic [WORD_W-1:0] w_src, w_dst;
  logic [PLEN_W-1:0] w_tlen;
  logic             w_last, w_odd;
  logic [IDX_W-1:0] w_tx, w_rx;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign bad         = (req_len_i == '0) || (64'(req_len_i) > 64'(MAX_TOTAL));
  assign load        = accept && !bad;
  assign adv         = (state_q == ST_EMIT) && (step_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= accept && bad;
      unique case (state_q)
        ST_IDLE: begin
          step_q <= '0;
          if (load) state_q <= ST_EMIT;
        end
        ST_EMIT: begin
          step_q <= step_q + 2'd1;
          if (adv && w_last) state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  chunk_walker #(
    .LEN_W(LEN_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .CHUNK_MAX(CHUNK_MAX)
  ) u_walk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (adv),
    .len_i    (req_len_i),
    .src_i    (req_src_i),
    .dst_i    (req_dst_i),
    .tx_i     (tx_idx_i),
    .rx_cpu_i (rx_cpu_idx_i),
    .src_o    (w_src),
    .dst_o    (w_dst),
    .tlen_o   (w_tlen),
    .last_o   (w_last),
    .odd_o    (w_odd),
    .tx_idx_o (w_tx),
    .rx_idx_o (w_rx)
  );

  desc_word_gen #(
    .IDX_W(IDX_W), .CHUNK_MAX(CHUNK_MAX)
  ) u_word (
    .step_i   (step_q),
    .src_i    (w_src),
    .dst_i    (w_dst),
    .tlen_i   (w_tlen),
    .last_i   (w_last),
    .odd_i    (w_odd),
    .tx_idx_i (w_tx),
    .rx_idx_i (w_rx),
    .ring_o   (wr_ring_o),
    .idx_o    (wr_idx_o),
    .word_o   (wr_word_o),
    .data_o   (wr_data_o)
  );

  assign wr_valid_o = (state_q == ST_EMIT);
  assign ctx_wr_o   = (state_q == ST_FIN);
  assign done_o     = (state_q == ST_FIN);
  assign ctx_idx_o  = w_tx;
  assign err_o      = err_q;

  a_r11_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> !req_ready_o);

  a_r8_ctx_after_rx_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_wr_o |-> $past(wr_valid_o) && $past(wr_ring_o) && ($past(wr_word_o) == 2'd1));

  a_r9_err_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !wr_valid_o && !done_o);

  a_r8_single_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/tb_copy_desc_packer.sv
module tb_copy_desc_packer;
  localparam int CHUNK = 16256;

  typedef struct {
    int          kind;  // 0 word write, 1 index update, 2 reject
    logic        ring;
    logic [2:0]  idx;
    logic [1:0]  word;
    logic [31:0] data;
    string       tag;
  } exp_t;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        req_valid_i = 0;
  logic        req_ready_o;
  logic [31:0] req_src_i = 0, req_dst_i = 0;
  logic [19:0] req_len_i = 0;
  logic [2:0]  tx_idx_i = 0, rx_cpu_idx_i = 0;
  logic        wr_valid_o, wr_ring_o, ctx_wr_o, done_o, err_o;
  logic [2:0]  wr_idx_o, ctx_idx_o;
  logic [1:0]  wr_word_o;
  logic [31:0] wr_data_o;

  int   checks = 0, errors = 0;
  bit   finished = 0;
  exp_t q[$];

  always #10 clk_i = ~clk_i;

  copy_desc_packer dut (.*);

  function automatic logic [31:0] flg(int p0, int p1, bit l0, bit l1);
    logic [31:0] f = 0;
    f[29:16] = p0[13:0];
    f[13:0]  = p1[13:0];
    f[30]    = l0;
    f[14]    = l1;
    return f;
  endfunction

  function automatic void push_w(logic r, logic [2:0] i, logic [1:0] w, logic [31:0] d, string t);
    exp_t e;
    e.kind = 0; e.ring = r; e.idx = i; e.word = w; e.data = d; e.tag = t;
    q.push_back(e);
  endfunction

  task automatic expect_req(int src, int dst, int len, int tx, int rx);
    int rem = len, s = src, d = dst, n = 0;
    logic [2:0] t = tx[2:0], r = rx[2:0] + 3'd1;
    exp_t e;
    if (len == 0 || len > 16 * CHUNK) begin
      e.kind = 2; e.tag = (len == 0) ? "R9" : "R10"; e.data = 0; e.ring = 0; e.idx = 0; e.word = 0;
      q.push_back(e);
      return;
    end
    while (rem > 0) begin
      int  tl = (rem > CHUNK) ? CHUNK : rem;
      bit  last = (rem <= CHUNK);
      if (n % 2 == 0) begin
        push_w(0, t, 0, s, "R3");
        push_w(0, t, 1, flg(tl, 0, last, 0), last ? "R5" : "R3");
      end else begin
        push_w(0, t - 3'd1, 2, s, "R4");
        push_w(0, t - 3'd1, 1, flg(CHUNK, tl, 0, last), last ? "R5" : "R4");
      end
      push_w(1, r, 0, d, "R6");
      push_w(1, r, 1, flg(tl, 0, 0, 0), "R2");
      if (n % 2 == 0) t = t + 3'd1;
      r = r + 3'd1;
      s += tl; d += tl; rem -= tl; n++;
    end
    e.kind = 1; e.idx = t; e.tag = "R8"; e.ring = 0; e.word = 0; e.data = 0;
    q.push_back(e);
  endtask

  task automatic send(int src, int dst, int len, int tx, int rx);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    expect_req(src, dst, len, tx, rx);
    req_src_i = src; req_dst_i = dst; req_len_i = len[19:0];
    tx_idx_i = tx[2:0]; rx_cpu_idx_i = rx[2:0];
    req_valid_i = 1;
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) if (rst_ni) begin
    if (wr_valid_o || ctx_wr_o || err_o) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R11: unexpected output v=%0b ctx=%0b err=%0b, expected none", wr_valid_o, ctx_wr_o, err_o);
      end else begin
        e = q.pop_front();
        if (e.kind == 0) begin
          if (!wr_valid_o || wr_ring_o !== e.ring || wr_idx_o !== e.idx ||
              wr_word_o !== e.word || wr_data_o !== e.data) begin
            errors++;
            $display("FAIL %s: v/ring/idx/word/data got %0b/%0d/%0d/%0d/%h exp 1/%0d/%0d/%0d/%h",
                     e.tag, wr_valid_o, wr_ring_o, wr_idx_o, wr_word_o, wr_data_o,
                     e.ring, e.idx, e.word, e.data);
          end
        end else if (e.kind == 1) begin
          if (!ctx_wr_o || !done_o || wr_valid_o || ctx_idx_o !== e.idx) begin
            errors++;
            $display("FAIL R8: ctx/done/v/idx got %0b/%0b/%0b/%0d exp 1/1/0/%0d",
                     ctx_wr_o, done_o, wr_valid_o, ctx_idx_o, e.idx);
          end
        end else begin
          if (!err_o || wr_valid_o || done_o) begin
            errors++;
            $display("FAIL %s: err/v/done got %0b/%0b/%0b exp 1/0/0", e.tag, err_o, wr_valid_o, done_o);
          end
        end
      end
    end
    if (wr_valid_o && req_ready_o) begin
      checks++; errors++;
      $display("FAIL R11: ready got 1 exp 0 while writing");
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    // R1 reset state
    repeat (2) @(negedge clk_i);
    checks++;
    if (req_ready_o !== 1 || wr_valid_o !== 0 || ctx_wr_o !== 0 || done_o !== 0 || err_o !== 0) begin
      errors++;
      $display("FAIL R1: rdy/v/ctx/done/err got %0b/%0b/%0b/%0b/%0b exp 1/0/0/0/0",
               req_ready_o, wr_valid_o, ctx_wr_o, done_o, err_o);
    end
    rst_ni = 1;
    @(negedge clk_i);
    checks++;
    if (req_ready_o !== 1 || wr_valid_o !== 0) begin
      errors++;
      $display("FAIL R1: after reset rdy/v got %0b/%0b exp 1/0", req_ready_o, wr_valid_o);
    end

    send(32'h1000_0000, 32'h2000_0000, 4, 0, 7);          // R6 rx wrap
    send(32'h1000_0100, 32'h2000_0100, CHUNK, 2, 1);       // R2 boundary inclusive
    send(32'h1100_0000, 32'h2100_0000, CHUNK + 1, 3, 3);   // R4, R5 even count
    send(32'h1200_0000, 32'h2200_0000, 2 * CHUNK + 77, 7, 5); // R3 tx wrap, R7
    send(32'h1300_0000, 32'h2300_0000, 0, 1, 1);           // R9
    send(32'h1400_0000, 32'h2400_0000, 16 * CHUNK, 4, 2);  // R10 largest legal
    send(32'h1500_0000, 32'h2500_0000, 16 * CHUNK + 1, 4, 2); // R10 rejected

    // R11: valid held during busy with other data must be ignored
    send(32'h1600_0000, 32'h2600_0000, CHUNK + 9, 5, 6);
    req_src_i = 32'hDEAD_0000; req_len_i = 20'd12; req_valid_i = 1;
    repeat (3) @(negedge clk_i);
    req_valid_i = 0;

    send(32'h1700_0003, 32'h2700_0005, 3 * CHUNK, 6, 0);

    while (q.size() != 0) @(negedge clk_i);
    repeat (5) @(negedge clk_i);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R8: pending expected items got %0d exp 0", q.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule